// File: doc/BRIEF.md
# Host Serial Register Port with Burst Access

This block is a four-wire serial slave that lets a host reach a small file of eight-bit registers. The host pulls chip select low and clocks in a command byte, least significant bit first. The command byte names a register, picks read or write, and can ask for a burst. Data bytes then follow, also least significant bit first. A write byte is sampled on rising serial-clock edges. A read byte is driven out on falling edges, together with an output-enable that a pad cell uses to tri-state the data-out line.

The serial clock, chip select and data-in pins are brought through synchronisers into a faster system clock and edge-detected, so the port sits wholly in that one domain. On its inner side the block drives a register address, a write strobe with write data, a read strobe (read data is expected back combinationally in that same cycle), and a two-bit clear pulse for the two status registers.

A burst starts only from address 0 and walks the registers in ascending order until chip select rises. A burst read never clears status. A single read of a status register does clear it. A rising chip select abandons whatever transfer is under way.

Top module: `hsp_regport`

## Requirements
- R1: The command byte arrives LSB first: bit 0 = 1 means read and 0 means write, bits 4:1 are the register address, bits 6:5 are reserved and must be 0, and bit 7 requests a burst.
- R2: After a write command, the next eight rising SCLK edges shift in a byte LSB first. One single-cycle `reg_wr_o` pulse then carries that byte on `reg_wdata_o` and the address on `reg_addr_o`.
- R3: After a read command, `reg_rd_o` pulses with the address, and the returned byte is driven on `sdo_o` LSB first. Each bit appears after a falling SCLK edge and is held until the next falling edge.
- R4: A command with a nonzero reserved field, or with an address of 11 to 15, reads back 0x00 and produces no write or read strobe.
- R5: Burst mode applies only when bit 7 is set and the address is 0. Otherwise exactly one byte is transferred: any further bytes read as 0x00 and writes are not strobed.
- R6: A burst accesses addresses 0, 1, … 10 in order, one per byte. After address 10, further read bytes are 0x00 and further write bytes produce no strobe.
- R7: `sdo_oe_o` is low whenever chip select is high and throughout write transfers. It is high during the data phase of a read.
- R8: A single (non-burst) valid read of address 5 pulses `stat_clr_o[0]`, and of address 7 pulses `stat_clr_o[1]`, once, after the byte's eighth rising edge. A burst read never pulses either bit.
- R9: A rising chip select aborts the transfer. A partial command or data byte is discarded with no strobe, and the next transfer starts with a fresh command byte.
- R10: During and directly after reset, `sdo_oe_o`, `sdo_o`, `reg_wr_o`, `reg_rd_o` and `stat_clr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out pad; 0 = high impedance |
| reg_addr_o | output | 4 | Register address for the current strobe |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the same cycle as `reg_rd_o` |
| stat_clr_o | output | 2 | Clear pulses for the status registers at addresses 5 and 7 |

## Verification
Every result lands a fixed number of system cycles after the SCLK edge that causes it. There are two synchroniser stages plus one edge-detect flop, and then one register stage for strobes, or two for the read-data load, so a result is due four to five cycles after the edge. The bench holds each SCLK phase for eight system cycles. It samples `sdo_o` and `sdo_oe_o` at the last falling system-clock edge before the next SCLK rise, which is safely after the output has settled and before the next falling edge can change it. Strobe and clear pulses are counted by a monitor, and those counts are checked only after chip select has risen and eight more cycles have passed, so every pending pulse has already appeared.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    // Command byte layout is fixed by the wire format.
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned BITCNT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Packed so that bit 0 of the received byte lands in 'rd'.
    typedef struct packed {
        logic              burst;
        logic [1:0]        rsv;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } cmd_t;

    function automatic logic cmd_ok(input cmd_t c, input int unsigned nregs);
        return (c.rsv == 2'b00) && (c.addr < ADDR_W'(nregs));
    endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync
    import hsp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_n_s,
    output logic sdi_s
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sdi_q;
    logic              sclk_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    sdi_q  <= '0;
                end else begin
                    sclk_q <= sclk_i;
                    cs_q   <= cs_n_i;
                    sdi_q  <= sdi_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_q <= '0;
                    cs_q   <= '1;
                    sdi_q  <= '0;
                end else begin
                    sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
                    cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
                    sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_q[TOP];
    end

    assign sclk_rise = sclk_q[TOP] & ~sclk_d & ~cs_q[TOP];
    assign sclk_fall = ~sclk_q[TOP] & sclk_d & ~cs_q[TOP];
    assign cs_n_s    = cs_q[TOP];
    assign sdi_s     = sdi_q[TOP];
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              sdi,
    output logic [DATA_W-1:0] byte_o,
    output logic              done_o
);
    logic [DATA_W-1:0]   sh_q;
    logic [BITCNT_W-1:0] cnt_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (shift) begin
            sh_q   <= {sdi, sh_q[DATA_W-1:1]};
            cnt_q  <= cnt_q + 1'b1;
            done_q <= (cnt_q == BITCNT_W'(DATA_W - 1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign byte_o = sh_q;
    assign done_o = done_q;
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sdo
);
    logic [DATA_W-1:0] sh_q;
    logic              sdo_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            sh_q  <= load_data;
        end else if (shift) begin
            sdo_q <= sh_q[0];
            sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/hsp_regport.sv
module hsp_regport
    import hsp_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 11,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STAT_ADDR_A = 5,
    parameter int unsigned STAT_ADDR_B = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic [1:0]        stat_clr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] STAT_A    = ADDR_W'(STAT_ADDR_A);
    localparam logic [ADDR_W-1:0] STAT_B    = ADDR_W'(STAT_ADDR_B);

    logic              sclk_rise, sclk_fall, cs_n_s, sdi_s;
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;
    cmd_t              cmd_in;
    logic              cmd_valid;

    phase_e            phase_q;
    logic              is_rd_q, ok_q, burst_q, oe_q;
    logic              load_q, live_q;
    logic [ADDR_W-1:0] cur_addr_q, addr_q;
    logic              wr_q, rd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        clr_q;
    logic              more_w;
    logic [DATA_W-1:0] tx_data;

    hsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .sdi_i     (sdi_i),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_n_s    (cs_n_s),
        .sdi_s     (sdi_s)
    );

    hsp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (cs_n_s),
        .shift  (sclk_rise),
        .sdi    (sdi_s),
        .byte_o (rx_byte),
        .done_o (rx_done)
    );

    assign tx_data = live_q ? reg_rdata_i : '0;

    hsp_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .clear     (cs_n_s),
        .load      (load_q),
        .load_data (tx_data),
        .shift     (sclk_fall),
        .sdo       (sdo_o)
    );

    assign cmd_in    = cmd_t'(rx_byte);
    assign cmd_valid = cmd_ok(cmd_in, NUM_REGS);
    assign more_w    = burst_q && (cur_addr_q != LAST_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CMD;
            is_rd_q    <= 1'b0;
            ok_q       <= 1'b0;
            burst_q    <= 1'b0;
            oe_q       <= 1'b0;
            load_q     <= 1'b0;
            live_q     <= 1'b0;
            cur_addr_q <= '0;
            addr_q     <= '0;
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
            wdata_q    <= '0;
            clr_q      <= '0;
        end else begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            load_q <= 1'b0;
            clr_q  <= '0;
            if (cs_n_s) begin
                phase_q <= PH_CMD;
                oe_q    <= 1'b0;
                burst_q <= 1'b0;
            end else if (rx_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        is_rd_q    <= cmd_in.rd;
                        ok_q       <= cmd_valid;
                        burst_q    <= cmd_valid && cmd_in.burst && (cmd_in.addr == '0);
                        cur_addr_q <= cmd_in.addr;
                        oe_q       <= cmd_in.rd;
                        phase_q    <= PH_DATA;
                        if (cmd_in.rd) begin
                            load_q <= 1'b1;
                            live_q <= cmd_valid;
                            rd_q   <= cmd_valid;
                            addr_q <= cmd_in.addr;
                        end
                    end
                    PH_DATA: begin
                        if (is_rd_q) begin
                            if (ok_q && !burst_q)
                                clr_q <= {cur_addr_q == STAT_B, cur_addr_q == STAT_A};
                        end else if (ok_q) begin
                            wr_q    <= 1'b1;
                            addr_q  <= cur_addr_q;
                            wdata_q <= rx_byte;
                        end
                        if (more_w) begin
                            cur_addr_q <= cur_addr_q + 1'b1;
                            if (is_rd_q) begin
                                load_q <= 1'b1;
                                live_q <= 1'b1;
                                rd_q   <= 1'b1;
                                addr_q <= cur_addr_q + 1'b1;
                            end
                        end else begin
                            phase_q <= PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdo_oe_o    = oe_q;
    assign reg_addr_o  = addr_q;
    assign reg_wr_o    = wr_q;
    assign reg_wdata_o = wdata_q;
    assign reg_rd_o    = rd_q;
    assign stat_clr_o  = clr_q;
endmodule

// File: rtl/hsp_regport_chk.sv
module hsp_regport_chk
    import hsp_pkg::*;
#(
    parameter int unsigned NUM_REGS = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n_s,
    input logic              burst_q,
    input logic              sdo_oe_o,
    input logic              reg_wr_o,
    input logic              reg_rd_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [1:0]        stat_clr_o
);
    // R7: output enable drops once synchronised chip select is high
    a_r7_oe_off_cs: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !sdo_oe_o);

    // R2: write strobe lasts one cycle
    a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    // R4: strobes never reach an address beyond the file
    a_r4_wr_range: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> (reg_addr_o < ADDR_W'(NUM_REGS)));

    a_r4_rd_range: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |-> (reg_addr_o < ADDR_W'(NUM_REGS)));

    // R8: at most one status clear at a time, never inside a burst
    a_r8_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat_clr_o));

    a_r8_clr_no_burst: assert property (@(posedge clk) disable iff (rst)
        (|stat_clr_o) |-> !burst_q);

    // R2: read and write strobes never coincide
    a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_o && reg_rd_o));
endmodule

bind hsp_regport hsp_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/tb_hsp_regport.sv
module tb_hsp_regport;
    logic       clk = 1'b0;
    logic       rst, cs_n, sclk, sdi;
    logic       sdo, sdo_oe, reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [1:0] stat_clr;

    int tests = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, clr0_cnt = 0, clr1_cnt = 0;
    logic oe_seen;
    logic [7:0] regs [11];

    always #4 clk = ~clk;

    hsp_regport dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr),
        .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata),
        .stat_clr_o(stat_clr)
    );

    // Register-file model on the inner side
    assign reg_rdata = (reg_addr < 4'd11) ? regs[reg_addr] : 8'h00;
    always @(posedge clk) begin
        if (reg_wr && reg_addr < 4'd11) regs[reg_addr] <= reg_wdata;
        if (reg_wr) wr_cnt <= wr_cnt + 1;
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (stat_clr[0]) clr0_cnt <= clr0_cnt + 1;
        if (stat_clr[1]) clr1_cnt <= clr1_cnt + 1;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic got);
        sdi = b;
        repeat (8) @(negedge clk);
        got = sdo;
        oe_seen = oe_seen | sdo_oe;
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
        for (int i = 0; i < 8; i++) sbit(d[i], q[i]);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        oe_seen = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_end();
        sclk = 1'b0;
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // {command, write data, expected read}
    localparam logic [23:0] VEC [9] = '{
        {8'h06, 8'hA5, 8'h00},   // write addr 3
        {8'h07, 8'h00, 8'hA5},   // read addr 3
        {8'h14, 8'h3C, 8'h00},   // write addr 10
        {8'h15, 8'h00, 8'h3C},   // read addr 10
        {8'h16, 8'h5A, 8'h00},   // write addr 11: ignored
        {8'h17, 8'h00, 8'h00},   // read addr 11: zero
        {8'h26, 8'h00, 8'h00},   // write addr 3, reserved set: ignored
        {8'h07, 8'h00, 8'hA5},   // read addr 3: unchanged
        {8'h27, 8'h00, 8'h00}    // read addr 3, reserved set: zero
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] q, dummy;
        int w0, c0, c1, r0;
        for (int i = 0; i < 11; i++) regs[i] = 8'h00;
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; oe_seen = 1'b0;
        repeat (5) @(negedge clk);
        // R10: idle outputs under reset
        chk(!sdo_oe && !sdo && !reg_wr && !reg_rd && stat_clr == 2'b00, "R10 reset",
            {sdo_oe, sdo, reg_wr, reg_rd, stat_clr}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!sdo_oe && !reg_wr && !reg_rd && stat_clr == 2'b00, "R10 after reset",
            {sdo_oe, reg_wr, reg_rd, stat_clr}, 0);

        // Vector table: R1 command layout, R2 writes, R3 reads, R4 invalid commands, R7 enable
        for (int v = 0; v < 9; v++) begin
            logic [7:0] cmd, wd, ex;
            logic valid;
            {cmd, wd, ex} = VEC[v];
            valid = (cmd[6:5] == 2'b00) && (cmd[4:1] <= 4'd10);
            w0 = wr_cnt;
            cs_begin();
            xbyte(cmd, dummy);
            oe_seen = 1'b0;
            xbyte(wd, q);
            cs_end();
            if (cmd[0]) begin
                chk(q == ex, valid ? "R3 read data" : "R4 invalid read zero", q, ex);
                chk(oe_seen, "R7 oe during read", oe_seen, 1);
            end else begin
                chk(wr_cnt - w0 == (valid ? 1 : 0), valid ? "R2 write strobe" : "R4 write ignored",
                    wr_cnt - w0, valid ? 1 : 0);
                chk(!oe_seen, "R7 oe low in write", oe_seen, 0);
            end
            chk(!sdo_oe, "R7 oe low with cs high", sdo_oe, 0);
        end

        // R6: burst write 0..10 then one extra byte
        w0 = wr_cnt;
        cs_begin();
        xbyte(8'h80, dummy);
        for (int i = 0; i < 12; i++) xbyte(8'h10 + 8'(i), dummy);
        cs_end();
        chk(wr_cnt - w0 == 11, "R6 burst write strobes", wr_cnt - w0, 11);
        chk(regs[10] == 8'h1A, "R6 burst last register", regs[10], 8'h1A);

        // R6/R8: burst read ascending, zero past end, no status clear
        c0 = clr0_cnt; c1 = clr1_cnt;
        cs_begin();
        xbyte(8'h81, dummy);
        for (int i = 0; i < 12; i++) begin
            xbyte(8'h00, q);
            chk(q == ((i < 11) ? 8'h10 + 8'(i) : 8'h00), "R6 burst read", q,
                (i < 11) ? 8'h10 + 8'(i) : 8'h00);
        end
        cs_end();
        chk(clr0_cnt == c0 && clr1_cnt == c1, "R8 burst read no clear",
            clr0_cnt + clr1_cnt, c0 + c1);

        // R5: burst bit with nonzero address gives a single byte
        cs_begin();
        xbyte(8'h85, dummy);
        xbyte(8'h00, q);
        chk(q == 8'h12, "R5 single read", q, 8'h12);
        xbyte(8'h00, q);
        chk(q == 8'h00, "R5 no advance read", q, 0);
        cs_end();
        w0 = wr_cnt;
        cs_begin();
        xbyte(8'h84, dummy);
        xbyte(8'h77, dummy);
        xbyte(8'h88, dummy);
        cs_end();
        chk(wr_cnt - w0 == 1 && regs[2] == 8'h77 && regs[3] == 8'h13, "R5 single write",
            {wr_cnt - w0, regs[2], regs[3]}, {32'd1, 8'h77, 8'h13});

        // R8: single reads of status addresses 5 and 7, and of 6
        c0 = clr0_cnt; c1 = clr1_cnt;
        cs_begin(); xbyte(8'h0B, dummy); xbyte(8'h00, q); cs_end();
        chk(q == 8'h15 && clr0_cnt == c0 + 1 && clr1_cnt == c1, "R8 clear addr 5",
            {q, 8'(clr0_cnt - c0), 8'(clr1_cnt - c1)}, {8'h15, 8'd1, 8'd0});
        cs_begin(); xbyte(8'h0F, dummy); xbyte(8'h00, q); cs_end();
        chk(clr0_cnt == c0 + 1 && clr1_cnt == c1 + 1, "R8 clear addr 7",
            clr1_cnt - c1, 1);
        cs_begin(); xbyte(8'h0D, dummy); xbyte(8'h00, q); cs_end();
        chk(clr0_cnt == c0 + 1 && clr1_cnt == c1 + 1, "R8 no clear addr 6",
            clr0_cnt + clr1_cnt, c0 + c1 + 2);

        // R9: abort inside a command byte, then inside a data byte
        w0 = wr_cnt; r0 = rd_cnt;
        cs_begin();
        for (int i = 0; i < 4; i++) sbit(1'b1, q[0]);
        cs_end();
        chk(wr_cnt == w0 && rd_cnt == r0, "R9 partial command no strobe",
            wr_cnt + rd_cnt, w0 + r0);
        cs_begin(); xbyte(8'h06, dummy);
        for (int i = 0; i < 4; i++) sbit(1'b1, q[0]);
        cs_end();
        chk(wr_cnt == w0, "R9 partial data no write", wr_cnt, w0);
        cs_begin(); xbyte(8'h07, dummy); xbyte(8'h00, q); cs_end();
        chk(q == 8'h13, "R9 fresh command after abort", q, 8'h13);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule